// File: doc/BRIEF.md
# Difficulty Weighted Score Display

This block keeps the running score of a game and shows it on a four-digit seven-segment display. Each time the game logic reports a completed course with a win pulse, the block adds an award that depends on the difficulty selected by two switches: 10, 20 or 30 points. The total is held as four BCD digits with a decimal carry between them. It stops at 9990 rather than wrapping.

The display is time-multiplexed. A refresh counter enables one digit at a time for a parameterised number of clock cycles. The default suits a 100 MHz clock with each digit refreshed at about 1 kHz. Segment lines and digit enables are active low. Leading zeros are blanked, and the ones digit is always shown. Debouncing of the switches and generation of the win pulse happen outside this block.

Top module: `score_display`

## Requirements
- R1: On every rising clock edge with `win_i` high, the total grows by 10 when `level_i` is 2'b00, by 20 when it is 2'b01 and by 30 when it is 2'b10. A win held high for n cycles adds the award n times.
- R2: The unused encoding `level_i` = 2'b11 awards 30, the same as the highest level.
- R3: While `win_i` is low the total does not change, whatever `level_i` does.
- R4: The total is four BCD digits, each in the range 0..9, with a decimal carry from each digit into the next higher one.
- R5: An award that would take the total past 9990 sets it to 9990. The total never wraps.
- R6: An active-low asynchronous reset `rst_ni` clears the total to 0. It restarts the scan at the ones digit, at the start of that digit's period.
- R7: Exactly one bit of `dig_n_o` is low at any time. Bit k drives decimal digit k, where bit 0 is the ones digit. Each digit stays enabled for DIGIT_CYCLES cycles, in the order ones, tens, hundreds, thousands, and then the order repeats.
- R8: `seg_n_o` bit 0 drives segment a and bit 6 drives segment g, all active low. The lit segments (a..g, active high) are: 0 = 0x3F, 1 = 0x06, 2 = 0x5B, 3 = 0x4F, 4 = 0x66, 5 = 0x6D, 6 = 0x7D, 7 = 0x07, 8 = 0x7F, 9 = 0x6F.
- R9: Digit k > 0 is blank, with `seg_n_o` = 7'h7F, when the total is below 10^k. The ones digit is never blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_i | input | 1 | Course completed, one award per high cycle |
| level_i | input | 2 | Difficulty setting from switches |
| seg_n_o | output | 7 | Segments a..g of the enabled digit, active low |
| dig_n_o | output | 4 | Digit enables, active low, bit 0 is the ones digit |

## Verification
The assertions assume that `win_i` and `level_i` are known, settled values at each rising edge. They also assume that the difficulty only matters in cycles where `win_i` is high. The bench meets this by changing every input on the falling edge, so each value is stable for half a period around the sampling edge. The bench steps through all four difficulty codes, including bursts where `win_i` stays high for several cycles, and runs until the total saturates. After each step it decodes the whole multiplexed display over one full scan to check the shown digits.

// File: rtl/score_pkg.sv
package score_pkg;

  typedef logic [3:0] bcd_t;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_SPARE = 2'b11
  } level_e;

  // award expressed as a tens digit
  function automatic bcd_t award_tens(input logic [1:0] lvl);
    case (level_e'(lvl))
      LVL_LOW:  return 4'd1;
      LVL_MID:  return 4'd2;
      default:  return 4'd3;
    endcase
  endfunction

  // segments a..g, active high, bit 0 = a
  function automatic logic [6:0] seg_lit(input bcd_t d);
    case (d)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/score_bcd_acc.sv
module score_bcd_acc
  import score_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         win_i,
  input  logic [1:0]                   level_i,
  output logic [NUM_DIGITS-1:0][3:0]   total_o
);

  localparam int unsigned SAT_VAL = (10 ** NUM_DIGITS) - 10;

  logic [NUM_DIGITS-1:0][3:0] total_q, sum, sat;
  logic [NUM_DIGITS:0]        carry;
  bcd_t                       award;

  assign award    = award_tens(level_i);
  assign carry[0] = 1'b0;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
    logic [4:0] raw;
    bcd_t       addend;
    if (d == 1) begin : g_tens
      assign addend = award;
    end else begin : g_zero
      assign addend = 4'd0;
    end
    assign raw          = {1'b0, total_q[d]} + {1'b0, addend} + {4'd0, carry[d]};
    assign carry[d+1]   = (raw > 5'd9);
    assign sum[d]       = carry[d+1] ? 4'(raw - 5'd10) : raw[3:0];
    assign sat[d]       = (d == 0) ? 4'd0 : 4'd9;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     total_q <= '0;
    else if (win_i)  total_q <= carry[NUM_DIGITS] ? sat : sum;
  end

  assign total_o = total_q;

  function automatic int unsigned to_int(input logic [NUM_DIGITS-1:0][3:0] v);
    int unsigned r;
    r = 0;
    for (int i = NUM_DIGITS - 1; i >= 0; i--) r = r * 10 + 32'(v[i]);
    return r;
  endfunction

  // R3
  a_r3_hold_without_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_i |=> $stable(total_q));

  // R1, R2
  a_r1_award_added: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && (to_int(total_q) + 32'(award) * 10 <= SAT_VAL))
      |=> to_int(total_q) == $past(to_int(total_q) + 32'(award) * 10));

  // R5
  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && (to_int(total_q) + 32'(award) * 10 > SAT_VAL))
      |=> to_int(total_q) == SAT_VAL);

  // R4
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_chk
    a_r4_digit_decimal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      total_q[d] <= 4'd9);
  end

endmodule

// File: rtl/score_digit_scan.sv
module score_digit_scan #(
  parameter int unsigned NUM_DIGITS   = 4,
  parameter int unsigned DIGIT_CYCLES = 25000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  output logic [$clog2(NUM_DIGITS)-1:0] sel_o,
  output logic [NUM_DIGITS-1:0]         dig_n_o
);

  localparam int unsigned CNT_W = (DIGIT_CYCLES > 1) ? $clog2(DIGIT_CYCLES) : 1;
  localparam int unsigned IDX_W = $clog2(NUM_DIGITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIGIT_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DIGITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             tick;

  assign tick = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_en
    assign dig_n_o[k] = (idx_q != IDX_W'(k));
  end

  assign sel_o = idx_q;

  // R7
  a_r7_one_digit_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~dig_n_o) == 1);

  a_r7_hold_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(dig_n_o));

  a_r7_next_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !dig_n_o[NUM_DIGITS-1]) |=> !dig_n_o[0]);

endmodule

// File: rtl/score_seg_drive.sv
module score_seg_drive
  import score_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_DIGITS-1:0][3:0]    total_i,
  input  logic [$clog2(NUM_DIGITS)-1:0] sel_i,
  output logic [6:0]                    seg_n_o
);

  logic [NUM_DIGITS-1:0] lead_zero;
  bcd_t                  cur;
  logic                  blank;

  // lead_zero[k]: digit k and all above it are zero
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_lz
    if (k == NUM_DIGITS - 1) begin : g_top
      assign lead_zero[k] = (total_i[k] == 4'd0);
    end else begin : g_mid
      assign lead_zero[k] = (total_i[k] == 4'd0) && lead_zero[k+1];
    end
  end

  assign cur   = total_i[sel_i];
  assign blank = (sel_i != '0) && lead_zero[sel_i];

  always_comb begin
    seg_n_o = ~seg_lit(cur);
    if (blank) seg_n_o = 7'h7F;
  end

  // R9: ones digit always shows a glyph
  a_r9_ones_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> (seg_n_o != 7'h7F));

  // R8: a shown digit always lights at least two segments
  a_r8_valid_glyph: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_n_o != 7'h7F) |-> ($countones(~seg_n_o) >= 2));

endmodule

// File: rtl/score_display.sv
module score_display #(
  parameter int unsigned NUM_DIGITS   = 4,
  parameter int unsigned DIGIT_CYCLES = 25000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  win_i,
  input  logic [1:0]            level_i,
  output logic [6:0]            seg_n_o,
  output logic [NUM_DIGITS-1:0] dig_n_o
);

  localparam int unsigned IDX_W = $clog2(NUM_DIGITS);

  logic [NUM_DIGITS-1:0][3:0] total;
  logic [IDX_W-1:0]           sel;

  score_bcd_acc #(.NUM_DIGITS(NUM_DIGITS)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .win_i   (win_i),
    .level_i (level_i),
    .total_o (total)
  );

  score_digit_scan #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_CYCLES(DIGIT_CYCLES)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_o   (sel),
    .dig_n_o (dig_n_o)
  );

  score_seg_drive #(.NUM_DIGITS(NUM_DIGITS)) u_seg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .total_i (total),
    .sel_i   (sel),
    .seg_n_o (seg_n_o)
  );

endmodule

// File: tb/score_display_test.sv
`timescale 1ns/1ps
module score_display_test;

  localparam int ND = 4;
  localparam int DC = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          win_i = 1'b0;
  logic [1:0]    level_i = 2'b00;
  logic [6:0]    seg_n_o;
  logic [ND-1:0] dig_n_o;

  int errors = 0;
  int checks = 0;
  int exp_total = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  score_display #(.NUM_DIGITS(ND), .DIGIT_CYCLES(DC)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_i(win_i), .level_i(level_i),
    .seg_n_o(seg_n_o), .dig_n_o(dig_n_o)
  );

  function automatic logic [6:0] glyph(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  function automatic logic [6:0] exp_seg(input int k, input int val);
    if (k > 0 && val < 10 ** k) return 7'h7F;
    return ~glyph((val / (10 ** k)) % 10);
  endfunction

  function automatic int award(input int lvl);
    return (lvl == 0) ? 10 : (lvl == 1) ? 20 : 30;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    win_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    exp_total = 0;
  endtask

  task automatic win(input int lvl, input int n);
    @(negedge clk_i);
    level_i = 2'(lvl);
    win_i = 1'b1;
    repeat (n) begin
      @(negedge clk_i);
      exp_total = exp_total + award(lvl);
      if (exp_total > 9990) exp_total = 9990;
    end
    win_i = 1'b0;
  endtask

  // one full scan; checks every shown digit against exp_total
  task automatic read_check(input string req);
    logic [6:0] got [ND];
    bit seen [ND];
    for (int k = 0; k < ND; k++) begin got[k] = '0; seen[k] = 0; end
    for (int c = 0; c < ND * DC; c++) begin
      @(negedge clk_i);
      for (int k = 0; k < ND; k++)
        if (dig_n_o == ~(ND'(1) << k)) begin got[k] = seg_n_o; seen[k] = 1; end
    end
    for (int k = 0; k < ND; k++)
      check(seen[k] && got[k] == exp_seg(k, exp_total), req, int'(got[k]),
            int'(exp_seg(k, exp_total)));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R6, R7: scan order and per-digit period straight after reset
    do_reset();
    for (int c = 0; c < 2 * ND * DC; c++) begin
      logic [ND-1:0] e;
      e = ~(ND'(1) << ((c / DC) % ND));
      check(dig_n_o == e, "R7 scan", int'(dig_n_o), int'(e));
      @(negedge clk_i);
    end
    read_check("R6 reset shows 0, R9 blanking");

    // R1, R2, R4, R8, R9: every level, several wins each
    for (int lvl = 0; lvl < 4; lvl++)
      for (int i = 0; i < 6; i++) begin
        win(lvl, 1);
        read_check(lvl == 3 ? "R2 spare level" : "R1 award");
      end

    // R1: win held for several cycles
    win(0, 3);
    read_check("R1 held win");
    win(1, 2);
    read_check("R1 held win");

    // R3: level changes without a win
    for (int lvl = 0; lvl < 4; lvl++) begin
      @(negedge clk_i);
      level_i = 2'(lvl);
      repeat (5) @(negedge clk_i);
      read_check("R3 no win");
    end

    // R4, R5: sweep to saturation with mixed levels
    do_reset();
    for (int i = 0; i < 470; i++) begin
      win(i % 4, 1);
      read_check(exp_total == 9990 ? "R5 saturate" : "R4 carry");
    end
    win(2, 4);
    read_check("R5 saturate held");

    // R6: reset from a full total
    do_reset();
    read_check("R6 reset clears");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule